// File: doc/BRIEF.md
# Serial Signature Analysis Register

This block compacts the serial response of a circuit under self-test into a short signature. Every response bit that arrives with its strobe enters a 5-bit division register. The register treats the stream as the coefficients of a polynomial, highest degree first, and divides it by the fixed divisor x^5 + x^4 + x^2 + 1. It throws the quotient away and keeps only the remainder. After the last response bit, the remainder is compared against a known-good signature supplied from outside, and a flag reports whether they agree.

A synchronous clear empties the register before each new collection. Idle cycles between strobes leave the register untouched, so the response source may stall freely. Bit i of the signature output is the coefficient of x^i in the remainder.

Top module: `serial_sig_analyzer`

## Requirements
- R1: When `clr` is high at a rising clock edge, the signature becomes all zeros after that edge, whatever `valid_i` and `data_i` are.
- R2: When `clr` and `valid_i` are both low at an edge, the signature keeps its value, whatever `data_i` is.
- R3: When `valid_i` is high and `clr` is low at an edge, the next signature equals the 6-bit value {old signature, `data_i`} reduced by XOR with 6'b110101 if its top bit is set, keeping the low 5 bits.
- R4: After a clear, the signature bit i is the x^i coefficient of the remainder of G(x) divided by x^5+x^4+x^2+1. G(x) is built from the strobed bits, with the first bit having the highest degree.
- R5: After a clear, the strobed stream 1,1,1,1,0,1,0,1 leaves the signature 5'b10100 (x^4 + x^2). Read from the x^0 end, this is 0,0,1,0,1.
- R6: `match_o` is high exactly when `sig_o` equals `expect_i`, in the same cycle and with no register between them.
- R7: After a clear, strobing the divisor itself (1,1,0,1,0,1) leaves the signature all zeros. The first five of those bits leave 5'b11010.
- R8: Zero bits strobed straight after a clear leave the signature all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of the signature, active high |
| valid_i | input | 1 | Strobe: `data_i` is a response bit this cycle |
| data_i | input | 1 | Serial response bit, highest-degree coefficient first |
| expect_i | input | SIG_W (5) | Known-good signature, bit i = x^i coefficient |
| sig_o | output | SIG_W (5) | Current remainder, bit i = x^i coefficient |
| match_o | output | 1 | High when `sig_o` equals `expect_i` |

## Verification
A bit strobed at one rising edge shows up in `sig_o` right after that edge. A clear likewise takes effect after the edge where it is sampled. The bench therefore changes inputs on the falling edge and reads `sig_o` at the next falling edge, one register later. `match_o` follows `sig_o` and `expect_i` with no register, so it is read a moment after `expect_i` changes, still clear of any edge. Each strobed bit is checked against a one-step model built from the previous observed signature. Each whole stream is checked against a long division of the collected bits.

// File: rtl/sig_analyzer_pkg.sv
`timescale 1ns/1ps
package sig_analyzer_pkg;

    // Remainder width equals the divisor degree.
    localparam int unsigned DEF_SIG_W = 5;

    // Divisor without its leading x^5 term: x^4 + x^2 + 1.
    localparam logic [DEF_SIG_W-1:0] DEF_TAPS = 5'b10101;

endpackage

// File: rtl/sig_div_step.sv
`timescale 1ns/1ps
// One division step: shift in a bit, subtract the divisor when the
// outgoing top coefficient is set.
module sig_div_step #(
    parameter int unsigned W    = 5,
    parameter logic [W-1:0] TAPS = 5'b10101
) (
    input  logic [W-1:0] state_i,
    input  logic         bit_i,
    output logic [W-1:0] next_o
);

    logic fb;
    assign fb = state_i[W-1];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign next_o[i] = bit_i ^ (TAPS[i] & fb);
        end else begin : g_up
            assign next_o[i] = state_i[i-1] ^ (TAPS[i] & fb);
        end
    end

endmodule

// File: rtl/sig_cmp.sv
`timescale 1ns/1ps
// Bitwise signature comparator.
module sig_cmp #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);

    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_diff
        assign diff[i] = a_i[i] ^ b_i[i];
    end

    assign eq_o = ~|diff;

endmodule

// File: rtl/serial_sig_analyzer.sv
`timescale 1ns/1ps
module serial_sig_analyzer
    import sig_analyzer_pkg::*;
#(
    parameter int unsigned      SIG_W = DEF_SIG_W,
    parameter logic [SIG_W-1:0] TAPS  = DEF_TAPS
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             valid_i,
    input  logic             data_i,
    input  logic [SIG_W-1:0] expect_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             match_o
);

    typedef struct packed {
        logic [SIG_W-1:0] sig;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [SIG_W-1:0] step_nxt;

    sig_div_step #(
        .W    (SIG_W),
        .TAPS (TAPS)
    ) u_step (
        .state_i (st_q.sig),
        .bit_i   (data_i),
        .next_o  (step_nxt)
    );

    sig_cmp #(
        .W (SIG_W)
    ) u_cmp (
        .a_i  (st_q.sig),
        .b_i  (expect_i),
        .eq_o (match_o)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sig = '0;
        end else if (valid_i) begin
            st_d.sig = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sig_o = st_q.sig;

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        clr |=> (sig_o == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
        !valid_i |=> $stable(sig_o)); // R2

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (clr)
        (valid_i && !sig_o[SIG_W-1]) |=> (sig_o[0] == $past(data_i))); // R3

    AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (clr)
        (valid_i && !sig_o[SIG_W-1]) |=> (sig_o[SIG_W-1] == $past(sig_o[SIG_W-2]))); // R3

    AST_FEEDBACK_LSB: assert property (@(posedge clk) disable iff (clr)
        (valid_i && sig_o[SIG_W-1]) |=> (sig_o[0] == (TAPS[0] ^ $past(data_i)))); // R3

    AST_MATCH_HIGH: assert property (@(posedge clk) disable iff (clr)
        (sig_o == expect_i) |-> match_o); // R6

    AST_MATCH_LOW: assert property (@(posedge clk) disable iff (clr)
        (sig_o != expect_i) |-> !match_o); // R6

endmodule

// File: tb/sim_serial_sig_analyzer.sv
`timescale 1ns/1ps
module sim_serial_sig_analyzer;

    localparam logic [5:0] DIV = 6'b110101;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       valid_i = 1'b0;
    logic       data_i = 1'b0;
    logic [4:0] expect_i = '0;
    logic [4:0] sig_o;
    logic       match_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] g_acc = '0;
    int          n_acc = 0;

    always #2.5 clk = ~clk;

    serial_sig_analyzer u0 (
        .clk      (clk),
        .clr      (clr),
        .valid_i  (valid_i),
        .data_i   (data_i),
        .expect_i (expect_i),
        .sig_o    (sig_o),
        .match_o  (match_o)
    );

    function automatic logic [4:0] rem_of(input logic [63:0] g, input int n);
        logic [63:0] t = g;
        for (int i = n - 1; i >= 5; i--) begin
            if (t[i]) t[i-:6] = t[i-:6] ^ DIV;
        end
        return t[4:0];
    endfunction

    function automatic logic [4:0] step_ref(input logic [4:0] prev, input logic b);
        logic [5:0] t = {prev, b};
        if (t[5]) t = t ^ DIV;
        return t[4:0];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic clear_reg();
        @(negedge clk);
        clr = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        g_acc = '0;
        n_acc = 0;
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        valid_i = 1'b1;
        data_i = b;
        g_acc = {g_acc[62:0], b};
        n_acc++;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic idle(input int k);
        logic [4:0] keep = sig_o;
        repeat (k) begin
            @(negedge clk);
            data_i = 1'($urandom % 2);
        end
        @(negedge clk);
        check(sig_o == keep, "R2 idle hold", sig_o, keep);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_dummy;
        logic [7:0]  pat;
        logic [5:0]  pp;
        logic [4:0]  prev;
        logic [4:0]  exp_r;
        logic [4:0]  keep;
        logic        b;
        int          len;

        seed_dummy = $urandom(32'd2718);

        // Reset state
        repeat (2) @(negedge clk);
        check(sig_o == 5'b0, "R1 reset value", sig_o, 5'b0);
        clr = 1'b0;
        g_acc = '0;
        n_acc = 0;

        // Worked residue
        pat = 8'b11110101;
        for (int i = 7; i >= 0; i--) send(pat[i]);
        check(sig_o == 5'b10100, "R5 worked residue", sig_o, 5'b10100);
        check(sig_o == rem_of(g_acc, n_acc), "R4 division model", sig_o, rem_of(g_acc, n_acc));
        expect_i = 5'b10100;
        #1;
        check(match_o == 1'b1, "R6 match equal", {4'b0, match_o}, 5'd1);
        expect_i = 5'b10101;
        #1;
        check(match_o == 1'b0, "R6 match differ", {4'b0, match_o}, 5'd0);

        // Idle cycles with toggling data
        idle(6);

        // Clear wins over a valid bit
        keep = sig_o;
        @(negedge clk);
        clr = 1'b1;
        valid_i = 1'b1;
        data_i = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        valid_i = 1'b0;
        check(sig_o == 5'b0, "R1 clear over valid", sig_o, 5'b0);
        check(keep != 5'b0, "R1 nonzero before clear", keep, 5'b10100);
        g_acc = '0;
        n_acc = 0;

        // Leading zeros
        for (int i = 0; i < 4; i++) begin
            send(1'b0);
            check(sig_o == 5'b0, "R8 leading zero", sig_o, 5'b0);
        end

        // Divisor stream
        clear_reg();
        pp = DIV;
        for (int i = 5; i >= 1; i--) send(pp[i]);
        check(sig_o == 5'b11010, "R7 partial divisor", sig_o, 5'b11010);
        send(pp[0]);
        check(sig_o == 5'b0, "R7 divisor leaves zero", sig_o, 5'b0);

        // Constrained random streams
        for (int s = 0; s < 24; s++) begin
            clear_reg();
            len = 1 + int'($urandom % 40);
            for (int k = 0; k < len; k++) begin
                prev = sig_o;
                b = 1'($urandom % 2);
                send(b);
                check(sig_o == step_ref(prev, b), "R3 single step", sig_o, step_ref(prev, b));
                if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
            end
            exp_r = rem_of(g_acc, n_acc);
            check(sig_o == exp_r, "R4 random stream remainder", sig_o, exp_r);
            expect_i = ($urandom % 2 == 0) ? exp_r : 5'($urandom);
            #1;
            check(match_o == (expect_i == exp_r), "R6 random compare",
                  {4'b0, match_o}, {4'b0, (expect_i == exp_r)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule